// File: doc/BRIEF.md
# Synchronous Dual-Ratio Clock Divider

This block takes one fast input clock and derives two slower clocks from it. The first output runs at one half or one quarter of the input rate. The second output runs at one quarter, one fifth or one sixth of the input rate. Both outputs are registered on the rising input edge. Each has its own phase counter, and the counters restart together at a shared boundary. A rising edge that both outputs make on the same input cycle is therefore produced by the same clock edge.

The run/hold control is active low. It is captured by a register on the falling input edge, so the dividers start and stop only between rising edges. An output pulse is never cut short. The active-low asynchronous reset puts every counter into a common pre-start phase. After release, every output makes its first rising edge on the same input edge, which lets several instances be aligned. New divide selections are loaded only when both counters complete a period together. At that point both outputs are low.

Top module: `clkdiv_dual`

## Requirements
- R1: With `sel_a_i` = 0, `div_a_o` divides by 2: high for 1 enabled input cycle, then low for 1.
- R2: With `sel_a_i` = 1, `div_a_o` divides by 4: high for 2 enabled cycles, then low for 2.
- R3: With `sel_b_i` = 2'b00, `div_b_o` divides by 4: high for 2 enabled cycles, then low for 2.
- R4: With `sel_b_i` = 2'b01, `div_b_o` divides by 6: high for 3 enabled cycles, then low for 3.
- R5: With `sel_b_i[1]` = 1, `div_b_o` divides by 5, high for 2 cycles and low for 3, and `sel_b_i[0]` is ignored.
- R6: On the first enabled rising edge after reset, both outputs go high together. Afterwards both outputs are high on every enabled cycle whose count is a multiple of both periods.
- R7: `en_ni` is sampled on the falling clock edge. While the sampled value is 1, both outputs hold their value. When it returns to 0, the pattern continues from where it stopped.
- R8: While `rst_ni` is low, both outputs are low at once, without waiting for a clock edge, and the dividers return to the pre-start phase.
- R9: A new selection takes effect only at the next enabled edge where both counters complete a period together. Until then the previous ratios continue.
- R10: Outputs change only on rising input edges. `div_b_o` is never high or low for fewer than 2 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| en_ni | input | 1 | Run when 0, hold when 1; captured on the falling clock edge |
| sel_a_i | input | 1 | Ratio select for output A (0: /2, 1: /4) |
| sel_b_i | input | 2 | Ratio select for output B (00: /4, 01: /6, 1x: /5) |
| div_a_o | output | 1 | Divided clock A |
| div_b_o | output | 1 | Divided clock B |

## Verification
The ratio pairs /2 with /4, /4 with /6, /2 with /5 and /4 with /5 (select bit 0 set) are each run for 60 cycles. Each run checks duty and period and shows that the shared edges stay aligned at multiples of both periods. The last pair is the one that shows select bit 0 is ignored when bit 1 is set. A hold that starts mid-period and is then released checks that the phase is frozen and then resumed, not restarted. A selection change made mid-frame shows whether loading waits for the shared boundary. An asynchronous reset in the middle of a high phase is checked between clock edges.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic {
    A_DIV2 = 1'b0,
    A_DIV4 = 1'b1
  } a_mode_e;

  typedef enum logic [1:0] {
    B_DIV4 = 2'd0,
    B_DIV6 = 2'd1,
    B_DIV5 = 2'd2
  } b_mode_e;

  typedef struct packed {
    a_mode_e a;
    b_mode_e b;
  } div_mode_t;

  localparam div_mode_t MODE_RST = '{a: A_DIV2, b: B_DIV4};
  localparam int unsigned MAX_PERIOD = 6;

  function automatic div_mode_t decode_sel(logic sa, logic [1:0] sb);
    div_mode_t m;
    m.a = sa ? A_DIV4 : A_DIV2;
    if (sb[1])      m.b = B_DIV5;
    else if (sb[0]) m.b = B_DIV6;
    else            m.b = B_DIV4;
    return m;
  endfunction

  function automatic int unsigned a_period(a_mode_e m);
    return (m == A_DIV4) ? 4 : 2;
  endfunction

  function automatic int unsigned a_high(a_mode_e m);
    return a_period(m) / 2;
  endfunction

  function automatic int unsigned b_period(b_mode_e m);
    case (m)
      B_DIV6:  return 6;
      B_DIV5:  return 5;
      default: return 4;
    endcase
  endfunction

  // /5 is 2 high, 3 low; others are 50 %
  function automatic int unsigned b_high(b_mode_e m);
    case (m)
      B_DIV6:  return 3;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/clkdiv_en_sync.sv
module clkdiv_en_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic run_o
);

  logic hold_q;

  // captured on the falling edge so gating lands while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b1;
    else         hold_q <= en_ni;
  end

  assign run_o = !hold_q;

endmodule

// File: rtl/clkdiv_phase_gen.sv
module clkdiv_phase_gen #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] last_i,
  input  logic [CNT_W-1:0] high_i,
  output logic             wrap_o,
  output logic             div_o
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             div_q;

  // reset value all-ones is past any last_i: the first enabled edge restarts at 0
  assign wrap_o  = (cnt_q >= last_i);
  assign cnt_nxt = wrap_o ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      div_q <= 1'b0;
    end else if (run_i) begin
      cnt_q <= cnt_nxt;
      div_q <= (cnt_nxt < high_i);
    end
  end

  assign div_o = div_q;

endmodule

// File: rtl/clkdiv_mode_ctrl.sv
module clkdiv_mode_ctrl
  import clkdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       wrap_all_i,
  input  logic       sel_a_i,
  input  logic [1:0] sel_b_i,
  output div_mode_t  mode_o
);

  div_mode_t mode_q;

  // load only where every counter restarts, outputs are then all low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  mode_q <= MODE_RST;
    else if (run_i && wrap_all_i) mode_q <= decode_sel(sel_a_i, sel_b_i);
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/clkdiv_dual.sv
module clkdiv_dual
  import clkdiv_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_ni,
  input  logic       sel_a_i,
  input  logic [1:0] sel_b_i,
  output logic       div_a_o,
  output logic       div_b_o
);

  localparam int unsigned NUM_CH = 2;

  logic                run;
  logic                wrap_all;
  div_mode_t           mode_q;
  logic [NUM_CH-1:0]   wrap;
  logic [NUM_CH-1:0]   div;
  logic [CNT_W-1:0]    last [NUM_CH];
  logic [CNT_W-1:0]    high [NUM_CH];

  clkdiv_en_sync u_en_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_ni  (en_ni),
    .run_o  (run)
  );

  clkdiv_mode_ctrl u_mode_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .wrap_all_i (wrap_all),
    .sel_a_i    (sel_a_i),
    .sel_b_i    (sel_b_i),
    .mode_o     (mode_q)
  );

  assign last[0] = CNT_W'(a_period(mode_q.a) - 1);
  assign high[0] = CNT_W'(a_high(mode_q.a));
  assign last[1] = CNT_W'(b_period(mode_q.b) - 1);
  assign high[1] = CNT_W'(b_high(mode_q.b));

  assign wrap_all = &wrap;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    clkdiv_phase_gen #(
      .CNT_W (CNT_W)
    ) u_phase (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .last_i (last[ch]),
      .high_i (high[ch]),
      .wrap_o (wrap[ch]),
      .div_o  (div[ch])
    );
  end

  assign div_a_o = div[0];
  assign div_b_o = div[1];

endmodule

// File: rtl/clkdiv_dual_chk.sv
module clkdiv_dual_chk
  import clkdiv_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      run_i,
  input div_mode_t mode_i,
  input logic      div_a_i,
  input logic      div_b_i
);

  AST_RST_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (!div_a_i && !div_b_i)); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(div_a_i) && $stable(div_b_i))); // R7

  AST_A_DIV2_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && div_a_i && mode_i.a == A_DIV2) |=> !div_a_i); // R1

  AST_B_MIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_b_i) |=> div_b_i); // R10

  AST_B_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_b_i) |=> !div_b_i); // R10

  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_i) |-> ($past(!div_a_i) && $past(!div_b_i))); // R9

endmodule

bind clkdiv_dual clkdiv_dual_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run),
  .mode_i  (mode_q),
  .div_a_i (div_a_o),
  .div_b_i (div_b_o)
);

// File: tb/clkdiv_dual_tb_top.sv
module clkdiv_dual_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_ni = 1'b0;
  logic       sel_a_i = 1'b0;
  logic [1:0] sel_b_i = 2'b00;
  logic       div_a_o, div_b_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i; // 125 MHz

  clkdiv_dual dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_ni   (en_ni),
    .sel_a_i (sel_a_i),
    .sel_b_i (sel_b_i),
    .div_a_o (div_a_o),
    .div_b_o (div_b_o)
  );

  function automatic logic pat(int k, int p, int h);
    return ((k % p) < h);
  endfunction

  task automatic check(string tag, int k, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s k=%0d actual=%b expected=%b", tag, k, act, exp);
    end
  endtask

  // reset, apply selects, release; returns at the sample point of enabled cycle 0
  task automatic start(logic sa, logic [1:0] sb);
    @(posedge clk_i); #1;
    rst_ni  = 1'b0;
    en_ni   = 1'b0;
    sel_a_i = sa;
    sel_b_i = sb;
    @(posedge clk_i); @(posedge clk_i); #1;
    check("R8 reset A", -1, div_a_o, 1'b0);
    check("R8 reset B", -1, div_b_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); #1;
  endtask

  task automatic next_sample();
    @(negedge clk_i); #1;
  endtask

  task automatic t_pattern(logic sa, logic [1:0] sb, int pa, int ha, int pb, int hb,
                           string ta, string tb);
    logic a_mid, b_mid;
    start(sa, sb);
    for (int k = 0; k < 60; k++) begin
      if (k > 0) next_sample();
      check(ta, k, div_a_o, pat(k, pa, ha));
      check(tb, k, div_b_o, pat(k, pb, hb));
      if ((k % pa) == 0 && (k % pb) == 0) begin
        check("R6 common rise A", k, div_a_o, 1'b1);
        check("R6 common rise B", k, div_b_o, 1'b1);
      end
      a_mid = div_a_o;
      b_mid = div_b_o;
      #2; // just before the next rising edge
      check("R10 stable A", k, div_a_o, a_mid);
      check("R10 stable B", k, div_b_o, b_mid);
    end
  endtask

  task automatic t_hold();
    start(1'b1, 2'b01); // /4 and /6
    for (int k = 0; k < 5; k++) begin
      if (k > 0) next_sample();
      check("R7 pre A", k, div_a_o, pat(k, 4, 2));
      check("R7 pre B", k, div_b_o, pat(k, 6, 3));
    end
    en_ni = 1'b1;
    next_sample();
    check("R7 last A", 5, div_a_o, pat(5, 4, 2));
    check("R7 last B", 5, div_b_o, pat(5, 6, 3));
    for (int i = 0; i < 6; i++) begin
      next_sample();
      check("R7 held A", 5, div_a_o, pat(5, 4, 2));
      check("R7 held B", 5, div_b_o, pat(5, 6, 3));
    end
    en_ni = 1'b0;
    next_sample();
    check("R7 release lag A", 5, div_a_o, pat(5, 4, 2));
    check("R7 release lag B", 5, div_b_o, pat(5, 6, 3));
    for (int k = 6; k < 20; k++) begin
      next_sample();
      check("R7 resume A", k, div_a_o, pat(k, 4, 2));
      check("R7 resume B", k, div_b_o, pat(k, 6, 3));
    end
  endtask

  task automatic t_mode_change();
    start(1'b0, 2'b00); // /2 and /4, frame of 4
    for (int k = 0; k < 30; k++) begin
      if (k > 0) next_sample();
      if (k < 4) begin
        check("R9 old A", k, div_a_o, pat(k, 2, 1));
        check("R9 old B", k, div_b_o, pat(k, 4, 2));
      end else begin
        check("R9 new A", k, div_a_o, pat(k - 4, 4, 2));
        check("R9 new B", k, div_b_o, pat(k - 4, 6, 3));
      end
      if (k == 1) begin
        sel_a_i = 1'b1;
        sel_b_i = 2'b01;
      end
    end
  endtask

  task automatic t_async_reset();
    start(1'b1, 2'b10);
    next_sample(); // k=1: both high
    check("R8 pre A", 1, div_a_o, 1'b1);
    check("R8 pre B", 1, div_b_o, 1'b1);
    rst_ni = 1'b0;
    #1;
    check("R8 async A", 1, div_a_o, 1'b0);
    check("R8 async B", 1, div_b_o, 1'b0);
    start(1'b1, 2'b10);
    check("R6 restart A", 0, div_a_o, 1'b1);
    check("R6 restart B", 0, div_b_o, 1'b1);
  endtask

  initial begin
    t_pattern(1'b0, 2'b00, 2, 1, 4, 2, "R1 A/2", "R3 B/4");
    t_pattern(1'b1, 2'b01, 4, 2, 6, 3, "R2 A/4", "R4 B/6");
    t_pattern(1'b0, 2'b10, 2, 1, 5, 2, "R1 A/2", "R5 B/5");
    t_pattern(1'b1, 2'b11, 4, 2, 5, 2, "R2 A/4", "R5 B/5 bit0 set");
    t_hold();
    t_mode_change();
    t_async_reset();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule